// File: doc/BRIEF.md
# ADC Burst and Tracking Sequencer

This block sits between a host and a successive-approximation ADC core and shapes each conversion. A single convert-start pulse becomes a power request, an optional track window and a one-cycle go strobe to the SAR engine. The sequence then holds until the engine answers with a done pulse. Timing is set by an 8-bit configuration byte with three fields: a power-up count, a tracking mode and a post-track length. Two control bits select how the core's power is managed: an enable bit and a burst bit.

Three tracking styles are supported. Post-tracking opens a track window after the start. Pre-tracking keeps the sampler tracking while the block is idle and fires the go strobe at once. Dual tracking does both. The post-track window counts SAR clock strobes and then adds two fast-clock cycles. In the burst low-power arrangement the core is unpowered between conversions. Each start then wakes it, and a wait of whole 200 ns ticks follows before tracking begins. A prescaler on the fast clock produces those ticks.

Top module: `adc_seq`

## Requirements
- R1: The configuration byte is read as power-up count P in bits 7:4, mode in bits 3:2 and post-track select S in bits 1:0. All three are captured on the clock that accepts a start, so later changes do not affect the running sequence.
- R2: With burst low, `pwr_on` equals `en`.
- R3: With burst and enable both high, `pwr_on` stays high, including during and between conversions.
- R4: With burst high and enable low, `pwr_on` is low while idle and rises on the cycle after an accepted start. No tracking is done and no go is issued for (P+1)*TICK_DIV cycles from that rise.
- R5: Mode 01 (post-tracking) does no tracking while idle. During a sequence, `track` rises on the first active cycle and stays high until 2<<S SAR strobes have been seen, then for 2 more cycles. `go` pulses on the next cycle.
- R6: Mode 10 (pre-tracking) keeps `track` high while idle and powered. `go` pulses on the first cycle after an accepted start, or on the first cycle after the wake wait, with no track window during the sequence.
- R7: Mode 11 (dual) tracks while idle as in R6 and also runs the post-track window of R5 before `go`.
- R8: Mode 00 behaves exactly as mode 01.
- R9: A `conv_start` received while `busy` is high is ignored: no second `go` is issued and the sequence length does not change.
- R10: `busy` rises on the cycle after an accepted start and falls on the cycle after `sar_done` arrives in the conversion phase. `go` is high for exactly one cycle per sequence.
- R11: After reset the block is idle, with `busy` and `go` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg | input | 8 | Configuration byte: power count, mode, post-track select |
| en | input | 1 | ADC enable |
| burst | input | 1 | Burst power-management select |
| sar_tick | input | 1 | One-cycle SAR clock-enable strobe |
| conv_start | input | 1 | Convert-start pulse |
| sar_done | input | 1 | Conversion finished pulse from the SAR engine |
| pwr_on | output | 1 | Power request to the ADC core |
| track | output | 1 | Track (sample) window |
| go | output | 1 | One-cycle conversion-go strobe |
| busy | output | 1 | Sequence in progress |

## Verification
A wrong sequencer state appears at the ports within one clock. It shows as `busy` failing to rise after a start, a go pulse longer than one cycle, or a go issued while `track` is still high. Counting errors in the wake or post-track counters appear only at the end of the window. They shift the `go` pulse by whole ticks or strobes, so the bench measures the go cycle exactly against the start, against the `pwr_on` rise and against the last SAR strobe. Ignored-start and done handling are judged by the number of go pulses and by the cycle on which `busy` falls.

// File: rtl/adc_seq.sv
`timescale 1ns/1ps
module adc_seq #(
  parameter int TICK_DIV = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cfg,
  input  logic       en,
  input  logic       burst,
  input  logic       sar_tick,
  input  logic       conv_start,
  input  logic       sar_done,
  output logic       pwr_on,
  output logic       track,
  output logic       go,
  output logic       busy
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  typedef enum logic [2:0] {S_IDLE, S_WAKE, S_POST, S_TAIL, S_GO, S_CONV} st_t;

  st_t           st;
  logic [7:0]    cfg_q;
  logic [3:0]    cnt;
  logic [PW-1:0] pre;

  function automatic st_t first_phase(input logic [1:0] m);
    return (m == 2'b10) ? S_GO : S_POST;
  endfunction

  wire       sleep  = burst & ~en;
  wire       tick   = (pre == PW'(TICK_DIV - 1));
  wire [4:0] n_last = (5'd2 << cfg_q[1:0]) - 5'd1;

  assign busy   = (st != S_IDLE);
  assign go     = (st == S_GO);
  assign pwr_on = burst ? (en | busy) : en;
  assign track  = (st == S_POST) || (st == S_TAIL) ||
                  ((st == S_IDLE) && cfg[3] && pwr_on);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cfg_q <= 8'hFF;
      cnt   <= '0;
      pre   <= '0;
    end else begin
      case (st)
        S_IDLE: if (conv_start) begin
          cfg_q <= cfg;
          cnt   <= '0;
          pre   <= '0;
          st    <= sleep ? S_WAKE : first_phase(cfg[3:2]);
        end
        S_WAKE: begin
          pre <= tick ? '0 : pre + 1'b1;
          if (tick) begin
            if (cnt == cfg_q[7:4]) begin
              cnt <= '0;
              st  <= first_phase(cfg_q[3:2]);
            end else cnt <= cnt + 1'b1;
          end
        end
        S_POST: if (sar_tick) begin
          if ({1'b0, cnt} == n_last) begin
            cnt <= '0;
            st  <= S_TAIL;
          end else cnt <= cnt + 1'b1;
        end
        S_TAIL: if (cnt == 4'd1) st <= S_GO;
                else cnt <= cnt + 1'b1;
        S_GO:   st <= S_CONV;
        S_CONV: if (sar_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_GO_SINGLE:    assert property (@(posedge clk) disable iff (!rst_n) go |=> !go);                 // R10
  AST_GO_BUSY:      assert property (@(posedge clk) disable iff (!rst_n) go |-> busy && !track);      // R10
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
                                     (st == S_CONV && sar_done) |=> !busy);                          // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
                                     (busy && conv_start && !(st == S_CONV && sar_done)) |=> busy);  // R9
  AST_SLEEP_OFF:    assert property (@(posedge clk) disable iff (!rst_n)
                                     (burst && !en && !busy) |-> !pwr_on);                          // R4
  AST_WAKE_QUIET:   assert property (@(posedge clk) disable iff (!rst_n)
                                     (st == S_WAKE) |-> (!track && !go && pwr_on));                 // R4
  AST_IDLE_TRACK_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
                                     (!busy && track) |-> pwr_on);                                  // R6
  AST_TAIL_TWO:     assert property (@(posedge clk) disable iff (!rst_n)
                                     (st == S_TAIL && $past(st) == S_TAIL) |=> go);                 // R5
endmodule

// File: tb/tb_adc_seq.sv
`timescale 1ns/1ps
module tb_adc_seq;
  localparam int DIV = 50;

  logic clk = 0, rst_n = 0;
  logic [7:0] cfg = 8'h00;
  logic en = 0, burst = 0, conv_start = 0, sar_done = 0;
  logic tick_en = 1;
  logic [1:0] tc = 0;
  logic sar_tick, pwr_on, track, go, busy;
  int vectors = 0, miscompares = 0;

  always #2 clk = ~clk;
  always_ff @(posedge clk) tc <= tc + 2'd1;
  assign sar_tick = tick_en && (tc == 2'd0);

  adc_seq #(.TICK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .en(en), .burst(burst),
    .sar_tick(sar_tick), .conv_start(conv_start), .sar_done(sar_done),
    .pwr_on(pwr_on), .track(track), .go(go), .busy(busy));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0, "R11 busy in reset", busy, 0);
    chk(go == 0, "R11 go in reset", go, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && go == 0, "R11 idle after reset", {busy, go}, 0);
  endtask

  task automatic t_power();
    burst = 0; en = 0; #1;
    chk(pwr_on == 0, "R2 burst off en off", pwr_on, 0);
    en = 1; #1;
    chk(pwr_on == 1, "R2 burst off en on", pwr_on, 1);
    burst = 1; #1;
    chk(pwr_on == 1, "R3 burst and en", pwr_on, 1);
    en = 0; #1;
    chk(pwr_on == 0, "R4 burst sleep idle", pwr_on, 0);
    @(negedge clk);
  endtask

  task automatic run(input logic [1:0] mode, input logic [1:0] sel,
                     input logic [3:0] pw, input string rq);
    int n = 2 << sel;
    bit wk = burst && !en;
    int w = wk ? (int'(pw) + 1) * DIV : 0;
    bit pre_m = (mode == 2'b10);
    int cyc = 1, go_cyc = -1, ticks = 0, last = -1, first_tr = -1, gos = 0;
    cfg = {pw, mode, sel};
    @(negedge clk);
    chk(track == (mode[1] && en), {rq, " idle track"}, track, mode[1] && en);
    if (wk) chk(pwr_on == 0, "R4 asleep before start", pwr_on, 0);
    conv_start = 1;
    @(negedge clk);
    conv_start = 0;
    cfg = ~cfg;  // R1: must not disturb running sequence
    chk(busy == 1, "R10 busy after start", busy, 1);
    if (wk) chk(pwr_on == 1, "R4 power after start", pwr_on, 1);
    while (cyc < 4000) begin
      if (busy && track && sar_tick) begin ticks++; last = cyc; end
      if (busy && track && first_tr < 0) first_tr = cyc;
      if (go) begin
        gos++;
        if (go_cyc < 0) begin
          go_cyc = cyc;
          chk(pwr_on == (burst ? 1'b1 : en), "R2/R3 power at go", pwr_on, burst ? 1 : en);
        end
      end
      if (go_cyc >= 0 && cyc == go_cyc + 3)
        chk(busy == 0, "R10 busy falls after done", busy, 0);
      if (go_cyc >= 0 && cyc == go_cyc + 5) begin
        chk(busy == 0, "R9 no restart", busy, 0);
        break;
      end
      conv_start = (cyc == 3) || (go_cyc >= 0 && cyc == go_cyc + 1);
      sar_done   = (go_cyc >= 0 && cyc == go_cyc + 2);
      @(negedge clk);
      cyc++;
    end
    conv_start = 0; sar_done = 0;
    chk(gos == 1, "R9 single go", gos, 1);
    if (pre_m) begin
      chk(go_cyc == w + 1, {rq, " go cycle"}, go_cyc, w + 1);
      chk(first_tr < 0, {rq, " no busy track"}, first_tr, -1);
    end else begin
      chk(first_tr == w + 1, {rq, " track start"}, first_tr, w + 1);
      chk(ticks == n, {rq, " R1 strobes in window"}, ticks, n);
      chk(go_cyc == last + 3, {rq, " go after tail"}, go_cyc, last + 3);
    end
    cfg = {pw, mode, sel};
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    miscompares++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset();
    t_power();
    burst = 0; en = 1;
    run(2'b01, 2'd0, 4'd5, "R5 post S0");
    run(2'b01, 2'd1, 4'd5, "R5 post S1");
    run(2'b01, 2'd2, 4'd5, "R5 post S2");
    run(2'b01, 2'd3, 4'd5, "R5 post S3");
    run(2'b10, 2'd0, 4'd5, "R6 pre");
    run(2'b11, 2'd1, 4'd5, "R7 dual");
    run(2'b00, 2'd2, 4'd5, "R8 reserved");
    burst = 1; en = 1;
    run(2'b01, 2'd0, 4'd9, "R3 burst powered");
    burst = 1; en = 0;
    run(2'b10, 2'd0, 4'd3, "R4 wake pre");
    run(2'b01, 2'd1, 4'd0, "R4 wake post");
    run(2'b11, 2'd0, 4'd1, "R4 wake dual");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule